// File: doc/BRIEF.md
# Bit-Mask Configured Register Bank

This block holds a small set of 8-bit registers. Two sides share them: a CPU bus and the on-chip logic around the block, here called the fabric. A constant table gives each bit of each register one of six access classes:

- read/write
- clear-on-read
- read-only
- write-only
- realtime passthrough
- unused

The table can mix classes freely inside one register. A second table places each register at its own CPU address. The addresses may leave gaps between them.

The CPU side presents an address, write data, a write enable and a read enable. It gets back read data from a register. The fabric side has three parts:

- Each register has an update enable and an 8-bit update value.
- Each register has an 8-bit live input for its realtime bits.
- One flat output carries every stored register value at once, so downstream logic can pick out the fields it needs.

The default configuration has six registers at addresses 0x04, 0x05, 0x08, 0x09, 0x10 and 0x1F. These are called A0 to A5, in that order.

- A0: all read/write, reset value 0x5A.
- A1: bits 3:0 clear-on-read, bits 7:4 read-only, reset value 0x00.
- A2: all write-only, reset value 0x00.
- A3: bits 3:0 read/write, bits 7:4 unused, reset value 0x03.
- A4: all realtime, reset value 0x00.
- A5: bits 1:0 read/write, bits 3:2 write-only, bits 5:4 clear-on-read, bits 7:6 realtime, reset value 0x01.

On the flat output, register n occupies bits 8n+7 down to 8n.

Top module: `mask_reg_bank`

## Requirements
- R1: While rst_n is low at a rising clock edge, every stored bit takes its reset value from the table and cpu_rdata becomes 0x00.
- R2: A CPU write (cpu_we high) to a mapped address loads cpu_wdata into that register's read/write bits. A later read returns them, for example A0 and A3 bits 3:0.
- R3: A CPU read returns the current value of the register's clear-on-read bits. The same edge then clears those bits to zero. This applies to A1 bits 3:0 and A5 bits 5:4.
- R4: A CPU write leaves read-only bits unchanged, for example A1 bits 7:4. A CPU read returns them.
- R5: A CPU write loads write-only bits, for example A2 and A5 bits 3:2. A CPU read returns 0 for them, while regs_out shows the stored value.
- R6: Realtime bits have no storage. A CPU read returns the value fab_rt_in had at the read edge, for example A4 and A5 bits 7:6. regs_out shows 0 for these bits.
- R7: Unused bits, for example A3 bits 7:4, read as 0 and show 0 on regs_out. A CPU write to them has no effect.
- R8: When fab_upd_en[n] is high at an edge, every stored bit of register n (all classes except realtime and unused) loads the matching bit of fab_upd_data.
- R9: Within one register, a fabric update overrides a CPU write in the same cycle. A fabric update also overrides a CPU read-clear in the same cycle.
- R10: A CPU write to an address outside the map changes no register. A CPU read of such an address returns 0x00.
- R11: cpu_rdata changes only at a rising edge where cpu_re is high, and shows the result of that read from then on. It holds its value in every cycle with cpu_re low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 8 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write enable |
| cpu_re | input | 1 | CPU read enable |
| cpu_rdata | output | 8 | Registered CPU read data |
| fab_upd_en | input | 6 | Fabric update enable, one bit per register |
| fab_upd_data | input | 48 | Fabric update values, register n in bits 8n+7:8n |
| fab_rt_in | input | 48 | Live realtime inputs, register n in bits 8n+7:8n |
| regs_out | output | 48 | All stored register values, register n in bits 8n+7:8n |

## Verification
The directed phase covers one class per step:

- An all-ones write to every mapped address shows which bits the CPU can write and which it cannot.
- A fabric load followed by two reads of the same register shows clear-on-read apart from plain read-only.
- Same-cycle collisions of a fabric update with a CPU write, and with a clear-on-read read, expose any fault in the priority order.
- Writes to and reads from unmapped addresses show whether the decoder treats gaps as holes.

A random phase then mixes reads, writes and fabric updates at mapped and unmapped addresses, with a realtime input that changes every cycle. A reset is applied partway through the run.

// File: rtl/mask_reg_bank_pkg.sv
// Package: shared types and the constant configuration tables of the bank.
// Assumes a small register count, so every table is computed by a function.
package mask_reg_bank_pkg;

    localparam int NUM_REGS = 6;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int FLAT_W   = NUM_REGS * DATA_W;

    typedef enum logic [2:0] {
        ACC_RW = 3'd0,   // CPU read/write, fabric write
        ACC_RC = 3'd1,   // CPU read clears, fabric write
        ACC_RO = 3'd2,   // CPU read only, fabric write
        ACC_WO = 3'd3,   // CPU write only, fabric write
        ACC_RT = 3'd4,   // unstored, live fabric input
        ACC_NU = 3'd5    // unused, reads zero
    } acc_e;

    // Per-bit access class of each register.
    function automatic acc_e acc_of(input int r, input int b);
        case (r)
            0: return ACC_RW;
            1: return (b < 4) ? ACC_RC : ACC_RO;
            2: return ACC_WO;
            3: return (b < 4) ? ACC_RW : ACC_NU;
            4: return ACC_RT;
            5: return (b >= 6) ? ACC_RT : (b >= 4) ? ACC_RC : (b >= 2) ? ACC_WO : ACC_RW;
            default: return ACC_NU;
        endcase
    endfunction

    // CPU address of each register; gaps between entries are allowed.
    function automatic logic [ADDR_W-1:0] addr_of(input int r);
        case (r)
            0: return 8'h04;
            1: return 8'h05;
            2: return 8'h08;
            3: return 8'h09;
            4: return 8'h10;
            5: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of each register (applies to stored bits only).
    function automatic logic [DATA_W-1:0] rst_of(input int r);
        case (r)
            0: return 8'h5A;
            3: return 8'h03;
            5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Bit mask of register r whose bits belong to class c.
    function automatic logic [DATA_W-1:0] cls_mask(input int r, input acc_e c);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (acc_of(r, b) == c) m[b] = 1'b1;
        end
        return m;
    endfunction

    // True when an address belongs to some register.
    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr_of(r) == a) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/rb_addr_decode.sv
// Module: compares the CPU address with every register address from the map.
// Assumes the map holds distinct addresses, so at most one hit is raised.
module rb_addr_decode
    import mask_reg_bank_pkg::*;
(
    input  logic [ADDR_W-1:0]   cpu_addr,
    output logic [NUM_REGS-1:0] hit
);

    // One comparator per register against its constant address.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cmp
        localparam logic [ADDR_W-1:0] REG_ADDR = addr_of(r);
        assign hit[r] = (cpu_addr == REG_ADDR);
    end

endmodule

// File: rtl/rb_bit_cell.sv
// Module: one bit of one register, built for the access class given by ACC.
// Assumes the fabric update has priority over CPU write and read-clear.
// Realtime and unused classes build no flop.
module rb_bit_cell
    import mask_reg_bank_pkg::*;
#(
    parameter acc_e ACC     = ACC_RW,
    parameter logic RST_BIT = 1'b0
)(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic upd_bit,
    input  logic cpu_wr,
    input  logic cpu_rd,
    input  logic wr_bit,
    input  logic rt_bit,
    output logic q_out,
    output logic rd_view
);

    localparam bit STORED = (ACC == ACC_RW) || (ACC == ACC_RC) ||
                            (ACC == ACC_RO) || (ACC == ACC_WO);
    localparam bit WR_OK  = (ACC == ACC_RW) || (ACC == ACC_WO);
    localparam bit CLR_OK = (ACC == ACC_RC);
    localparam bit VIS_OK = (ACC == ACC_RW) || (ACC == ACC_RC) || (ACC == ACC_RO);

    if (STORED) begin : g_stored
        logic st;
        logic unused_rt;

        // Stored bit: reset, fabric load, CPU write, then read-clear, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                 st <= RST_BIT;
            else if (upd_en)            st <= upd_bit;
            else if (cpu_wr && WR_OK)   st <= wr_bit;
            else if (cpu_rd && CLR_OK)  st <= 1'b0;
        end

        assign q_out     = st;
        assign rd_view   = VIS_OK ? st : 1'b0;
        assign unused_rt = rt_bit;
    end else if (ACC == ACC_RT) begin : g_realtime
        logic unused_rt_in;
        assign q_out        = 1'b0;
        assign rd_view      = rt_bit;
        assign unused_rt_in = ^{clk, rst_n, upd_en, upd_bit, cpu_wr, cpu_rd, wr_bit};
    end else begin : g_unused
        logic unused_nu_in;
        assign q_out        = 1'b0;
        assign rd_view      = 1'b0;
        assign unused_nu_in = ^{clk, rst_n, upd_en, upd_bit, cpu_wr, cpu_rd, wr_bit, rt_bit};
    end

endmodule

// File: rtl/rb_read_port.sv
// Module: selects the read view of the addressed register and registers it.
// Assumes hit is one-hot or zero; zero hits give 0x00.
module rb_read_port
    import mask_reg_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_re,
    input  logic [NUM_REGS-1:0] hit,
    input  logic [FLAT_W-1:0]   view,
    output logic [DATA_W-1:0]   cpu_rdata
);

    logic [DATA_W-1:0] sel;

    // AND-OR select of the addressed register's read view.
    always_comb begin
        sel = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) sel = sel | view[r*DATA_W +: DATA_W];
        end
    end

    // Read data register, loaded only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= '0;
        else if (cpu_re) cpu_rdata <= sel;
    end

endmodule

// File: rtl/mask_reg_bank.sv
// Module: top of the register bank; per-bit cells built from the class table.
// Assumes the CPU issues at most one access address per cycle.
// A read and a write to the same address may coincide.
module mask_reg_bank
    import mask_reg_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                cpu_we,
    input  logic                cpu_re,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic [NUM_REGS-1:0] fab_upd_en,
    input  logic [FLAT_W-1:0]   fab_upd_data,
    input  logic [FLAT_W-1:0]   fab_rt_in,
    output logic [FLAT_W-1:0]   regs_out
);

    logic [NUM_REGS-1:0] hit;
    logic [FLAT_W-1:0]   view;

    rb_addr_decode u_dec (
        .cpu_addr (cpu_addr),
        .hit      (hit)
    );

    // Bit-cell array: one cell per bit, variant chosen by the class table.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [DATA_W-1:0] RST = rst_of(r);
        logic wr_sel;
        logic rd_sel;
        assign wr_sel = hit[r] & cpu_we;
        assign rd_sel = hit[r] & cpu_re;
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            rb_bit_cell #(
                .ACC     (acc_of(r, b)),
                .RST_BIT (RST[b])
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd_en  (fab_upd_en[r]),
                .upd_bit (fab_upd_data[r*DATA_W + b]),
                .cpu_wr  (wr_sel),
                .cpu_rd  (rd_sel),
                .wr_bit  (cpu_wdata[b]),
                .rt_bit  (fab_rt_in[r*DATA_W + b]),
                .q_out   (regs_out[r*DATA_W + b]),
                .rd_view (view[r*DATA_W + b])
            );
        end
    end

    rb_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_re    (cpu_re),
        .hit       (hit),
        .view      (view),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/mask_reg_bank_chk.sv
// Module: property checker for the register bank, bound to the top module.
// Assumes only the top-level ports are visible.
module mask_reg_bank_chk
    import mask_reg_bank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic                cpu_we,
    input logic                cpu_re,
    input logic [DATA_W-1:0]   cpu_rdata,
    input logic [NUM_REGS-1:0] fab_upd_en,
    input logic [FLAT_W-1:0]   fab_upd_data,
    input logic [FLAT_W-1:0]   fab_rt_in,
    input logic [FLAT_W-1:0]   regs_out
);

    AST_RESET_RDATA_ZERO: assert property (@(posedge clk) !rst_n |=> cpu_rdata == '0); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_re |=> $stable(cpu_rdata)); // R11

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !is_mapped(cpu_addr)) |=> cpu_rdata == '0); // R10

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
        localparam logic [DATA_W-1:0] SM = cls_mask(r, ACC_RW) | cls_mask(r, ACC_RC) |
                                           cls_mask(r, ACC_RO) | cls_mask(r, ACC_WO);
        localparam logic [DATA_W-1:0] RCM = cls_mask(r, ACC_RC);

        AST_FAB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            fab_upd_en[r] |=> (regs_out[r*DATA_W +: DATA_W] & SM) ==
                              ($past(fab_upd_data[r*DATA_W +: DATA_W]) & SM)); // R8

        AST_NOSTORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_out[r*DATA_W +: DATA_W] & ~SM) == '0); // R7

        AST_RC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_re && cpu_addr == addr_of(r) && !fab_upd_en[r]) |=>
                (regs_out[r*DATA_W +: DATA_W] & RCM) == '0); // R3
    end

endmodule

bind mask_reg_bank mask_reg_bank_chk u_chk (.*);

// File: tb/tb_mask_reg_bank.sv
// Bench: behavioural reference model compared with the design on every clock.
module tb_mask_reg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_we, cpu_re;
    logic [5:0]  fab_upd_en;
    logic [47:0] fab_upd_data, fab_rt_in, regs_out;

    mask_reg_bank dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
        .fab_upd_en(fab_upd_en), .fab_upd_data(fab_upd_data),
        .fab_rt_in(fab_rt_in), .regs_out(regs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Configuration, written out from the requirement text.
    function automatic logic [7:0] t_addr(int r);
        case (r) 0: return 8'h04; 1: return 8'h05; 2: return 8'h08;
                 3: return 8'h09; 4: return 8'h10; default: return 8'h1F; endcase
    endfunction
    function automatic logic [7:0] t_rst(int r);
        case (r) 0: return 8'h5A; 3: return 8'h03; 5: return 8'h01; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] m_rw(int r);
        case (r) 0: return 8'hFF; 3: return 8'h0F; 5: return 8'h03; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] m_rc(int r);
        case (r) 1: return 8'h0F; 5: return 8'h30; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] m_ro(int r);
        return (r == 1) ? 8'hF0 : 8'h00;
    endfunction
    function automatic logic [7:0] m_wo(int r);
        case (r) 2: return 8'hFF; 5: return 8'h0C; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] m_rt(int r);
        case (r) 4: return 8'hFF; 5: return 8'hC0; default: return 8'h00; endcase
    endfunction

    // Reference model state.
    logic [7:0] st [NR];
    logic [7:0] m_rdata;

    // Model update at each rising edge, from the inputs held over that edge.
    always @(posedge clk) begin
        int idx;
        logic [7:0] nxt, sm, wm;
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) st[r] = t_rst(r);
            m_rdata = 8'h00;
        end else begin
            idx = -1;
            for (int r = 0; r < NR; r++) if (t_addr(r) == cpu_addr) idx = r;
            if (cpu_re)
                m_rdata = (idx < 0) ? 8'h00 :
                          ((st[idx] & (m_rw(idx) | m_rc(idx) | m_ro(idx))) |
                           (fab_rt_in[idx*8 +: 8] & m_rt(idx)));
            for (int r = 0; r < NR; r++) begin
                sm  = m_rw(r) | m_rc(r) | m_ro(r) | m_wo(r);
                wm  = m_rw(r) | m_wo(r);
                nxt = st[r];
                if (idx == r && cpu_re) nxt = nxt & ~m_rc(r);
                if (idx == r && cpu_we) nxt = (nxt & ~wm) | (cpu_wdata & wm);
                if (fab_upd_en[r]) nxt = (nxt & ~sm) | (fab_upd_data[r*8 +: 8] & sm);
                st[r] = nxt;
            end
        end
    end

    function automatic logic [47:0] exp_flat();
        logic [47:0] f;
        for (int r = 0; r < NR; r++)
            f[r*8 +: 8] = st[r] & (m_rw(r) | m_rc(r) | m_ro(r) | m_wo(r));
        return f;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Advance to the next falling edge and compare both outputs with the model.
    task automatic cyc();
        @(negedge clk);
        checks++;
        if (cpu_rdata !== m_rdata) begin
            errors++;
            $display("FAIL %s cpu_rdata actual=%h expected=%h", cur_req, cpu_rdata, m_rdata);
        end
        checks++;
        if (regs_out !== exp_flat()) begin
            errors++;
            $display("FAIL %s regs_out actual=%h expected=%h", cur_req, regs_out, exp_flat());
        end
    endtask

    task automatic idle();
        cpu_we = 0; cpu_re = 0; fab_upd_en = '0;
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        idle(); cpu_addr = a; cpu_wdata = d; cpu_we = 1; cyc();
    endtask
    task automatic rd(input logic [7:0] a);
        idle(); cpu_addr = a; cpu_re = 1; cyc();
    endtask
    task automatic fab(input int r, input logic [7:0] d);
        idle(); fab_upd_en[r] = 1'b1; fab_upd_data[r*8 +: 8] = d; cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        rst_n = 0; idle(); cpu_addr = 0; cpu_wdata = 0;
        fab_upd_data = '0; fab_rt_in = '0;
        repeat (2) @(negedge clk);
        cur_req = "R1";
        cyc();                                    // reset values, R1
        rst_n = 1;
        for (int r = 0; r < NR; r++) rd(t_addr(r));
        cur_req = "R2";
        for (int r = 0; r < NR; r++) wr(t_addr(r), 8'hFF);   // R2 R4 R5 R7
        for (int r = 0; r < NR; r++) rd(t_addr(r));
        cur_req = "R4";
        wr(8'h05, 8'h00); rd(8'h05);              // R4 read-only ignores write
        cur_req = "R7";
        wr(8'h09, 8'hA5); rd(8'h09);              // R7 unused bits stay zero
        cur_req = "R5";
        wr(8'h08, 8'h3C); rd(8'h08);              // R5 write-only reads zero
        cur_req = "R6";
        fab_rt_in = 48'hC3_5A_00_00_00_00; rd(8'h10); rd(8'h1F);
        fab_rt_in = 48'h81_96_00_00_00_00; rd(8'h10); rd(8'h1F);
        cur_req = "R8";
        fab(1, 8'hB7); fab(5, 8'hFF); fab(0, 8'h11);
        cur_req = "R3";
        rd(8'h05); rd(8'h05); rd(8'h1F); rd(8'h1F);           // read then cleared
        cur_req = "R9";
        idle(); cpu_addr = 8'h04; cpu_wdata = 8'hEE; cpu_we = 1;
        fab_upd_en[0] = 1; fab_upd_data[7:0] = 8'h42; cyc();  // fabric beats write
        rd(8'h04);
        idle(); cpu_addr = 8'h05; cpu_re = 1;
        fab_upd_en[1] = 1; fab_upd_data[15:8] = 8'h0F; cyc(); // set beats clear
        rd(8'h05);
        cur_req = "R10";
        wr(8'h00, 8'hFF); wr(8'h06, 8'hFF); wr(8'hFF, 8'hFF);
        rd(8'h06); rd(8'h20);
        cur_req = "R11";
        rd(8'h04);
        idle(); cpu_addr = 8'h05; cyc(); cpu_addr = 8'h06; cyc();
        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            int k;
            idle();
            k = $urandom_range(0, 7);
            cpu_addr  = (k < 6) ? t_addr(k) : ((k == 6) ? 8'h07 : 8'h11);
            cpu_wdata = 8'($urandom);
            cpu_we    = ($urandom_range(0, 2) == 0);
            cpu_re    = ($urandom_range(0, 1) == 0);
            fab_upd_en   = 6'($urandom) & 6'($urandom);
            fab_upd_data = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            fab_rt_in    = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if (i == 200) begin cur_req = "R1"; rst_n = 0; end
            if (i == 202) begin rst_n = 1; cur_req = "R9"; end
            cyc();
        end
        idle(); cyc();
        done = 1;
        summary();
    end

endmodule